// File: doc/BRIEF.md
# Dual-Phase Serial Receive Framer

This block turns a serial bit stream into parallel words grouped into frames. A single-cycle bit-clock enable qualifies every input. A frame-sync input, seen on such an enable, opens a new frame. The data bits that follow are gathered MSB first into words.

A frame has one phase or two. Each phase has its own word width and its own word count, set on static configuration inputs. In two-phase mode the words of the first phase arrive first and the words of the second phase follow in the same frame. The number of words in a frame is the number of channel slots between two sync pulses.

Each finished word is presented right-justified on a 32-bit bus with a one-cycle valid strobe. The strobe is tagged with the phase it belongs to and its slot number within that phase. A run input that is low holds the receiver in reset. A frame sync that cuts a frame short restarts reception and sets a sticky error flag.

Top module: `dual_phase_rx_framer`

## Requirements
- R1: While `rxRun` is 0 the receiver is held in reset. No word is produced, `busy` is 0 and `frameErr` is cleared, whatever arrives on the serial inputs.
- R2: The 3-bit width code of a phase selects the bits per word. Code 0 selects 8, 1 selects 12, 2 selects 16, 3 selects 20, 4 selects 24, and 5, 6 and 7 all select 32.
- R3: Bits are taken MSB first. The completed word appears on `wordData` right-justified, and every bit above the word width is 0.
- R4: The 7-bit count field of a phase holds the number of words minus one, so a phase carries 1 to 128 words. `wordSlot` numbers the words of a phase from 0 up to the field value.
- R5: With `cfgDual` at 1 a frame carries the phase-1 words first (`wordPhase` 0, phase-1 width and count), then the phase-2 words (`wordPhase` 1, phase-2 width and count).
- R6: With `cfgDual` at 0 only the phase-1 width and count are used. Every word carries `wordPhase` 0, whatever the phase-2 settings are.
- R7: Inputs count only on cycles with `bitEn` at 1. A `frameSync` of 1 on such a cycle opens a frame at phase 1, slot 0. The data bit on that cycle is not taken, and the first data bit is the one on the next enabled cycle.
- R8: A sync on an enabled cycle while a frame is still in progress drops the partial word and restarts at phase 1, slot 0. It also sets `frameErr`, which stays at 1 until `rxRun` goes low.
- R9: After the last word of the last phase the receiver goes idle and ignores data bits until the next sync. A sync on an idle receiver does not set `frameErr`.
- R10: `wordValid` is high for exactly one clock, the cycle after the clock edge that sampled the last bit of the word. `wordData`, `wordPhase` and `wordSlot` are valid during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxRun | input | 1 | Receiver run control; 0 holds the receiver in reset |
| bitEn | input | 1 | Bit-clock enable, one cycle per serial bit |
| serData | input | 1 | Serial data bit |
| frameSync | input | 1 | Frame-sync pulse, qualified by `bitEn` |
| cfgDual | input | 1 | 1 selects two-phase frames |
| cfgLen1 | input | 3 | Word width code for phase 1 |
| cfgLen2 | input | 3 | Word width code for phase 2 |
| cfgCount1 | input | 7 | Phase-1 word count minus one |
| cfgCount2 | input | 7 | Phase-2 word count minus one |
| wordValid | output | 1 | One-cycle strobe for a completed word |
| wordData | output | 32 | Completed word, right-justified |
| wordPhase | output | 1 | Phase of the word: 0 for phase 1, 1 for phase 2 |
| wordSlot | output | 7 | Slot index of the word within its phase |
| frameErr | output | 1 | Sticky flag for a frame cut short by a sync |
| busy | output | 1 | A frame is in progress |

## Verification
The edge that samples the final bit of a word is the edge that raises `wordValid`. That edge also updates the data, phase and slot tags, so each result is due one clock after the enabled cycle that carried the last bit. `frameErr` rises on the edge that samples the interrupting sync. The bench drives inputs on falling edges and holds each bit's enable for one cycle. During the idle cycle between bits it drives an inverted data bit and a raised sync, and both must be ignored. It samples outputs on the falling edge that follows the sampling edge, and one directed test checks that the strobe is absent the cycle before and the cycle after.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic clrShift;  // start of frame: empty the shift register
    logic shiftIn;   // take serData into the shift register
    logic loadWord;  // last bit of a word: present the word
  } rxStrobe_t;

  localparam int LEN_W = 6;

  // Width code to bits per word; unused codes fall back to the widest word
  function automatic logic [LEN_W-1:0] decodeLen(input logic [2:0] code);
    case (code)
      3'd0:    decodeLen = 6'd8;
      3'd1:    decodeLen = 6'd12;
      3'd2:    decodeLen = 6'd16;
      3'd3:    decodeLen = 6'd20;
      3'd4:    decodeLen = 6'd24;
      default: decodeLen = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/rxfr_ctrl.sv
module rxfr_ctrl
  import rxfr_pkg::*;
#(
  parameter int COUNT_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxRun,
  input  logic               bitEn,
  input  logic               frameSync,
  input  logic               cfgDual,
  input  logic [2:0]         cfgLen1,
  input  logic [2:0]         cfgLen2,
  input  logic [COUNT_W-1:0] cfgCount1,
  input  logic [COUNT_W-1:0] cfgCount2,
  output rxStrobe_t          strobe,
  output logic               curPhase,
  output logic [COUNT_W-1:0] curSlot,
  output logic               frameErr,
  output logic               busy
);

  localparam logic [COUNT_W-1:0] SLOT_ONE = COUNT_W'(1);
  localparam logic [LEN_W-1:0]   BIT_ONE  = LEN_W'(1);

  logic               active;
  logic               phase;
  logic [COUNT_W-1:0] slot;
  logic [LEN_W-1:0]   bitCnt;
  logic               errFlag;

  logic [LEN_W-1:0]   curLen;
  logic [COUNT_W-1:0] curCount;
  logic               startFrame;
  logic               takeBit;
  logic               lastBit;
  logic               lastSlot;
  logic               lastPhase;

  always_comb begin
    curLen     = decodeLen(phase ? cfgLen2 : cfgLen1);
    curCount   = phase ? cfgCount2 : cfgCount1;
    startFrame = rxRun && bitEn && frameSync;
    takeBit    = rxRun && bitEn && !frameSync && active;
    lastBit    = takeBit && (bitCnt == curLen - BIT_ONE);
    lastSlot   = (slot == curCount);
    lastPhase  = !cfgDual || phase;
  end

  always_comb begin
    strobe.clrShift = startFrame;
    strobe.shiftIn  = takeBit && !lastBit;
    strobe.loadWord = lastBit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      slot    <= '0;
      bitCnt  <= '0;
      errFlag <= 1'b0;
    end else if (!rxRun) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      slot    <= '0;
      bitCnt  <= '0;
      errFlag <= 1'b0;
    end else if (startFrame) begin
      errFlag <= errFlag | active;
      active  <= 1'b1;
      phase   <= 1'b0;
      slot    <= '0;
      bitCnt  <= '0;
    end else if (takeBit) begin
      if (lastBit) begin
        bitCnt <= '0;
        if (lastSlot) begin
          slot <= '0;
          if (lastPhase) begin
            active <= 1'b0;
            phase  <= 1'b0;
          end else begin
            phase <= 1'b1;
          end
        end else begin
          slot <= slot + SLOT_ONE;
        end
      end else begin
        bitCnt <= bitCnt + BIT_ONE;
      end
    end
  end

  assign curPhase = phase;
  assign curSlot  = slot;
  assign frameErr = errFlag;
  assign busy     = active;

  // R1: a low run input leaves the receiver idle and the flag cleared
  a_r1_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rxRun |=> (!busy && !frameErr));

  // R2: the bit counter never passes the width of the current phase
  a_r2_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bitCnt < curLen));

  // R4: the slot counter stays within the programmed count
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot <= curCount));

  // R6: single-phase frames never reach the second phase
  a_r6_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfgDual) |-> !phase);

  // R8: the error flag rises only after a sync that hit a running frame
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frameErr) |-> $past(frameSync && bitEn && busy));

endmodule

// File: rtl/rxfr_data.sv
module rxfr_data
  import rxfr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rxStrobe_t          strobe,
  input  logic               serData,
  input  logic               phaseTag,
  input  logic [COUNT_W-1:0] slotTag,
  output logic               wordValid,
  output logic [DATA_W-1:0]  wordData,
  output logic               wordPhase,
  output logic [COUNT_W-1:0] wordSlot
);

  // Holds every bit of a word but its last; the last comes straight from serData
  logic [DATA_W-2:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strobe.clrShift || strobe.loadWord) begin
      shiftReg <= '0;
    end else if (strobe.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-3:0], serData};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordValid <= 1'b0;
      wordData  <= '0;
      wordPhase <= 1'b0;
      wordSlot  <= '0;
    end else begin
      wordValid <= strobe.loadWord;
      if (strobe.loadWord) begin
        wordData  <= {shiftReg, serData};
        wordPhase <= phaseTag;
        wordSlot  <= slotTag;
      end
    end
  end

  // R10: the word strobe lasts one cycle (a word takes at least eight bits)
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wordValid |=> !wordValid);

endmodule

// File: rtl/dual_phase_rx_framer.sv
module dual_phase_rx_framer
  import rxfr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxRun,
  input  logic               bitEn,
  input  logic               serData,
  input  logic               frameSync,
  input  logic               cfgDual,
  input  logic [2:0]         cfgLen1,
  input  logic [2:0]         cfgLen2,
  input  logic [COUNT_W-1:0] cfgCount1,
  input  logic [COUNT_W-1:0] cfgCount2,
  output logic               wordValid,
  output logic [DATA_W-1:0]  wordData,
  output logic               wordPhase,
  output logic [COUNT_W-1:0] wordSlot,
  output logic               frameErr,
  output logic               busy
);

  rxStrobe_t          strobe;
  logic               curPhase;
  logic [COUNT_W-1:0] curSlot;

  rxfr_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxRun     (rxRun),
    .bitEn     (bitEn),
    .frameSync (frameSync),
    .cfgDual   (cfgDual),
    .cfgLen1   (cfgLen1),
    .cfgLen2   (cfgLen2),
    .cfgCount1 (cfgCount1),
    .cfgCount2 (cfgCount2),
    .strobe    (strobe),
    .curPhase  (curPhase),
    .curSlot   (curSlot),
    .frameErr  (frameErr),
    .busy      (busy)
  );

  rxfr_data #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .serData   (serData),
    .phaseTag  (curPhase),
    .slotTag   (curSlot),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordPhase (wordPhase),
    .wordSlot  (wordSlot)
  );

  // R3: bits above the width of the word's phase are zero
  a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wordValid |-> ((wordData >> decodeLen(wordPhase ? cfgLen2 : cfgLen1)) == '0));

  // R6: single-phase words always carry phase 0
  a_r6_phase_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (wordValid && !cfgDual) |-> !wordPhase);

endmodule

// File: tb/test_dual_phase_rx_framer.sv
module test_dual_phase_rx_framer;

  localparam int CLK_PERIOD = 10;
  localparam int CAP_MAX    = 300;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxRun = 1'b0;
  logic        bitEn = 1'b0;
  logic        serData = 1'b0;
  logic        frameSync = 1'b0;
  logic        cfgDual = 1'b0;
  logic [2:0]  cfgLen1 = 3'd0;
  logic [2:0]  cfgLen2 = 3'd0;
  logic [6:0]  cfgCount1 = 7'd0;
  logic [6:0]  cfgCount2 = 7'd0;
  logic        wordValid;
  logic [31:0] wordData;
  logic        wordPhase;
  logic [6:0]  wordSlot;
  logic        frameErr;
  logic        busy;

  int nChecks = 0;
  int nFail   = 0;
  int capN    = 0;
  int cycles  = 0;
  logic [31:0] capData  [CAP_MAX];
  logic        capPhase [CAP_MAX];
  logic [6:0]  capSlot  [CAP_MAX];

  dual_phase_rx_framer i_dual_phase_rx_framer (
    .clk(clk), .rst_n(rst_n), .rxRun(rxRun), .bitEn(bitEn), .serData(serData),
    .frameSync(frameSync), .cfgDual(cfgDual), .cfgLen1(cfgLen1), .cfgLen2(cfgLen2),
    .cfgCount1(cfgCount1), .cfgCount2(cfgCount2), .wordValid(wordValid),
    .wordData(wordData), .wordPhase(wordPhase), .wordSlot(wordSlot),
    .frameErr(frameErr), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Record every word strobe, sampled away from the rising edge
  always @(negedge clk) begin
    if (wordValid) begin
      if (capN < CAP_MAX) begin
        capData[capN]  = wordData;
        capPhase[capN] = wordPhase;
        capSlot[capN]  = wordSlot;
      end
      capN = capN + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > WATCHDOG) begin
      nChecks = nChecks + 1;
      nFail   = nFail + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFail = nFail + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] code);
    case (code)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int k);
    return 32'h6B1D_E395 ^ (32'(k) * 32'h0104_2081);
  endfunction

  function automatic logic [31:0] maskTo(input logic [31:0] w, input int len);
    if (len >= 32) return w;
    return w & ((32'd1 << len) - 32'd1);
  endfunction

  // One enabled bit, then one disabled cycle carrying misleading inputs (R7)
  task automatic sendBit(input logic sync, input logic d);
    @(negedge clk);
    bitEn = 1'b1; frameSync = sync; serData = d;
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b1; serData = ~d;
  endtask

  task automatic sendWord(input logic [31:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) sendBit(1'b0, w[i]);
  endtask

  task automatic settle();
    @(negedge clk);
    frameSync = 1'b0;
    @(negedge clk);
  endtask

  // Full frame, with its words checked against the configuration
  task automatic runFrame(input logic dual, input logic [2:0] l1, input logic [6:0] c1,
                          input logic [2:0] l2, input logic [6:0] c2, input string req);
    int base;
    int n1;
    int n2;
    int idx;
    cfgDual = dual; cfgLen1 = l1; cfgCount1 = c1; cfgLen2 = l2; cfgCount2 = c2;
    base = capN;
    n1 = int'(c1) + 1;
    n2 = dual ? int'(c2) + 1 : 0;
    sendBit(1'b1, 1'b1);  // R7: bit beside the sync is not data
    for (int k = 0; k < n1; k++) sendWord(pat(k), lenOf(l1));
    for (int k = 0; k < n2; k++) sendWord(pat(200 + k), lenOf(l2));
    settle();
    chk(capN - base == n1 + n2, req, "word count", 32'(capN - base), 32'(n1 + n2));
    for (int k = 0; k < n1 + n2; k++) begin
      idx = base + k;
      if (idx < CAP_MAX && k < capN - base) begin
        if (k < n1) begin
          chk(capData[idx] == maskTo(pat(k), lenOf(l1)), req, "phase-1 data",
              capData[idx], maskTo(pat(k), lenOf(l1)));
          chk(capPhase[idx] == 1'b0, req, "phase-1 tag", 32'(capPhase[idx]), 0);
          chk(capSlot[idx] == 7'(k), req, "phase-1 slot", 32'(capSlot[idx]), 32'(k));
        end else begin
          chk(capData[idx] == maskTo(pat(200 + k - n1), lenOf(l2)), req, "phase-2 data",
              capData[idx], maskTo(pat(200 + k - n1), lenOf(l2)));
          chk(capPhase[idx] == 1'b1, req, "phase-2 tag", 32'(capPhase[idx]), 1);
          chk(capSlot[idx] == 7'(k - n1), req, "phase-2 slot", 32'(capSlot[idx]), 32'(k - n1));
        end
      end
    end
  endtask

  task automatic testReset();
    int base;
    chk(wordValid == 1'b0, "R1", "valid after reset", 32'(wordValid), 0);
    chk(frameErr == 1'b0, "R1", "error after reset", 32'(frameErr), 0);
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
    base = capN;
    cfgDual = 1'b0; cfgLen1 = 3'd0; cfgCount1 = 7'd0;
    sendBit(1'b1, 1'b0);
    sendWord(32'hA5, 8);
    settle();
    chk(capN == base, "R1", "words while held", 32'(capN - base), 0);
    chk(busy == 1'b0, "R1", "busy while held", 32'(busy), 0);
    rxRun = 1'b1;
  endtask

  task automatic testSingle();
    runFrame(1'b0, 3'd0, 7'd2, 3'd5, 7'd9, "R6");
    runFrame(1'b0, 3'd2, 7'd1, 3'd0, 7'd0, "R3");
    chk(frameErr == 1'b0, "R9", "error after back-to-back frames", 32'(frameErr), 0);
  endtask

  task automatic testLengths();
    for (int c = 0; c < 8; c++) runFrame(1'b0, 3'(c), 7'd0, 3'd0, 7'd0, "R2");
  endtask

  task automatic testDual();
    runFrame(1'b1, 3'd1, 7'd1, 3'd5, 7'd2, "R5");
    runFrame(1'b1, 3'd4, 7'd0, 3'd0, 7'd3, "R5");
  endtask

  task automatic testIdle();
    int base;
    base = capN;
    for (int i = 0; i < 40; i++) sendBit(1'b0, 1'(i % 3));
    settle();
    chk(capN == base, "R9", "words while idle", 32'(capN - base), 0);
    chk(busy == 1'b0, "R9", "busy while idle", 32'(busy), 0);
    chk(frameErr == 1'b0, "R9", "error while idle", 32'(frameErr), 0);
  endtask

  task automatic testTiming();
    cfgDual = 1'b0; cfgLen1 = 3'd0; cfgCount1 = 7'd0;
    sendBit(1'b1, 1'b0);
    sendWord(32'h5A, 7);  // upper seven bits of 8'hB5
    @(negedge clk);
    bitEn = 1'b1; frameSync = 1'b0; serData = 1'b1;
    chk(wordValid == 1'b0, "R10", "valid before last bit", 32'(wordValid), 0);
    @(negedge clk);
    bitEn = 1'b0;
    chk(wordValid == 1'b1, "R10", "valid after last bit", 32'(wordValid), 1);
    chk(wordData == 32'hB5, "R10", "data with strobe", wordData, 32'hB5);
    @(negedge clk);
    chk(wordValid == 1'b0, "R10", "valid one cycle later", 32'(wordValid), 0);
    chk(busy == 1'b0, "R9", "idle after last word", 32'(busy), 0);
    settle();
  endtask

  task automatic testAbort();
    int base;
    cfgDual = 1'b0; cfgLen1 = 3'd0; cfgCount1 = 7'd3;
    base = capN;
    sendBit(1'b1, 1'b0);
    sendWord(32'h3C, 8);
    sendWord(32'hF, 4);
    chk(capN - base == 1, "R8", "words before abort", 32'(capN - base), 1);
    chk(frameErr == 1'b0, "R8", "error before abort", 32'(frameErr), 0);
    runFrame(1'b0, 3'd0, 7'd3, 3'd0, 7'd0, "R8");
    chk(frameErr == 1'b1, "R8", "error after abort", 32'(frameErr), 1);
    runFrame(1'b0, 3'd1, 7'd0, 3'd0, 7'd0, "R8");
    chk(frameErr == 1'b1, "R8", "error stays set", 32'(frameErr), 1);
    @(negedge clk);
    rxRun = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(frameErr == 1'b0, "R8", "error cleared by run low", 32'(frameErr), 0);
    rxRun = 1'b1;
  endtask

  task automatic testMaxCount();
    runFrame(1'b0, 3'd0, 7'd127, 3'd0, 7'd0, "R4");
    chk(capSlot[capN - 1] == 7'd127, "R4", "last slot", 32'(capSlot[capN - 1]), 127);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testLengths();
    testDual();
    testIdle();
    testTiming();
    testAbort();
    testMaxCount();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule